// File: doc/BRIEF.md
# UART Register Read Remapping

This block is the register-file and address-decode slice of a 16550-style UART. It holds the interrupt-enable, line-control, modem-control, index and extended-status registers. It also decodes a simple synchronous bus into writes to those registers and into a registered read-data value. The UART core supplies the line status, the two FIFO fill levels and the contents of an external set of indexed control registers as plain inputs. The block hands the stored register values back to the core.

Two bits of a local remap-control register change how the address map behaves. The indexed-read bit (bit 6) makes reads at the line-status address return the indexed control register selected by the index register. The extended-status bit (bit 7) makes the line-control and modem-control addresses write-only: reads there return the transmit and receive FIFO levels instead. The same bit gives the interrupt-enable address to a separate status register for both reads and writes. The remap-control register is the indexed location at index 0 and is held inside this block. Writes to every other index, such as the clock-select register at index 0x03, are forwarded to the external indexed file.

Address map: 1 = interrupt enable / extended status, 3 = line control / transmit level, 4 = modem control / receive level, 5 = line status / indexed data, 7 = index. Addresses 0, 2 and 6 are not decoded.

Top module: `uart_remap_regs`

## Requirements
- R1: After a synchronous active-low reset, bus_rdata, the interrupt-enable, line-control, modem-control, extended-status, index and remap-control registers are all zero.
- R2: A read strobe at a clock edge loads bus_rdata with the addressed value at that edge. While no read strobe is given, bus_rdata keeps its last value.
- R3: With bit 7 of remap control clear, writes at addresses 1, 3 and 4 update the interrupt-enable, line-control and modem-control registers, and reads at those addresses return them.
- R4: With bit 7 set, reads at address 3 return tx_level and reads at address 4 return rx_level, zero-extended. Writes at 3 and 4 still update line control and modem control.
- R5: With bit 7 set, writes at address 1 update the extended-status register and leave interrupt enable unchanged, and reads at address 1 return the extended-status register.
- R6: With bit 7 clear, writes at address 1 leave the extended-status register unchanged, and reads at address 1 return interrupt enable.
- R7: Reads at address 5 return line_status when bit 6 of remap control is 0. When bit 6 is 1 they return the indexed register: the remap-control value at index 0, otherwise icr_rdata.
- R8: Writes at address 7 set the index register, which drives icr_index, and reads at address 7 return it.
- R9: A write at address 5 with index 0 loads remap control. With any other index (for example clock select at 0x03) it raises icr_wr for that bus cycle with icr_wdata equal to the write data, and remap control is left unchanged.
- R10: Reads at addresses 0, 2 and 6 return zero.
- R11: A read and a write at the same address in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| line_status | input | DATA_W | Line status from the UART core |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| icr_rdata | input | DATA_W | Contents of the external indexed register selected by icr_index |
| icr_index | output | IDX_W | Current index |
| icr_wr | output | 1 | Write strobe to the external indexed file |
| icr_wdata | output | DATA_W | Write data to the external indexed file |
| ier_q | output | DATA_W | Interrupt-enable register |
| lcr_q | output | DATA_W | Line-control register |
| mcr_q | output | DATA_W | Modem-control register |
| asr_q | output | DATA_W | Extended-status register |
| remap_ctl | output | DATA_W | Remap-control register |

## Verification
A stored register takes a write at the clock edge that samples the strobe, so the bench checks the register outputs on the falling edge after that edge. bus_rdata is loaded at the edge that samples the read strobe and is compared on the following falling edge. icr_wr and icr_wdata are combinational from the bus, so the bench checks them 1 ns after driving the strobe and before the edge. Hold behaviour is checked by leaving the read strobe low for further cycles and confirming bus_rdata has not moved.

// File: rtl/uart_remap_pkg.sv
// Package: shared address map and remap-control bit positions for the
// UART register remapping slice. Assumes a 3-bit register address.
package uart_remap_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_IER = 3'd1;  // interrupt enable / extended status
    localparam logic [ADDR_W-1:0] A_LCR = 3'd3;  // line control / transmit level
    localparam logic [ADDR_W-1:0] A_MCR = 3'd4;  // modem control / receive level
    localparam logic [ADDR_W-1:0] A_LSR = 3'd5;  // line status / indexed data
    localparam logic [ADDR_W-1:0] A_IDX = 3'd7;  // index register

    localparam int CTL_IDX_RD = 6;  // remap-control bit: indexed reads at A_LSR
    localparam int CTL_EXT    = 7;  // remap-control bit: extended status map
endpackage

// File: rtl/urr_regs.sv
// urr_regs: write decode and storage for the stored registers.
// Holds interrupt enable, line control, modem control, extended status,
// index and the local remap-control register (indexed location CTL_IDX).
// Writes to other indexes are forwarded combinationally to an external file.
// Assumes DATA_W >= 8 so that both remap-control bits exist.
module urr_regs
    import uart_remap_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 8,
    parameter int CTL_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ier,
    output logic [DATA_W-1:0] lcr,
    output logic [DATA_W-1:0] mcr,
    output logic [DATA_W-1:0] asr,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] ctl,
    output logic              icr_wr,
    output logic [DATA_W-1:0] icr_wdata
);
    localparam logic [IDX_W-1:0] CTL_AT = IDX_W'(CTL_IDX);

    logic ext_map;
    logic idx_is_ctl;
    logic wr_ier, wr_asr, wr_lcr, wr_mcr, wr_idx, wr_ctl;

    // Decode which register a write strobe targets under the current map.
    always_comb begin
        ext_map    = ctl[CTL_EXT];
        idx_is_ctl = (idx == CTL_AT);
        wr_ier     = wr && (addr == A_IER) && !ext_map;
        wr_asr     = wr && (addr == A_IER) &&  ext_map;
        wr_lcr     = wr && (addr == A_LCR);
        wr_mcr     = wr && (addr == A_MCR);
        wr_idx     = wr && (addr == A_IDX);
        wr_ctl     = wr && (addr == A_LSR) &&  idx_is_ctl;
        icr_wr     = wr && (addr == A_LSR) && !idx_is_ctl;
        icr_wdata  = wdata;
    end

    // Update the stored registers on their decoded write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier <= '0;
            lcr <= '0;
            mcr <= '0;
            asr <= '0;
            idx <= '0;
            ctl <= '0;
        end else begin
            if (wr_ier) ier <= wdata;
            if (wr_asr) asr <= wdata;
            if (wr_lcr) lcr <= wdata;
            if (wr_mcr) mcr <= wdata;
            if (wr_idx) idx <= wdata[IDX_W-1:0];
            if (wr_ctl) ctl <= wdata;
        end
    end

    // R5: extended map protects interrupt enable from writes at A_IER.
    a_r5_ier_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_IER && ctl[CTL_EXT]) |=> (ier == $past(ier)));

    // R6: normal map keeps extended status out of reach of writes.
    a_r6_asr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_IER && !ctl[CTL_EXT]) |=> (asr == $past(asr)));

    // R9: a forwarded indexed write never alters the local remap control.
    a_r9_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        icr_wr |=> (ctl == $past(ctl)));
endmodule

// File: rtl/urr_rdmux.sv
// urr_rdmux: combinational read decode. Selects the value a read at addr
// returns under the current remap-control bits. Levels are zero-extended.
// Assumes LVL_W <= DATA_W and IDX_W <= DATA_W.
module urr_rdmux
    import uart_remap_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LVL_W   = 8,
    parameter int IDX_W   = 8,
    parameter int CTL_IDX = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] ctl,
    input  logic [DATA_W-1:0] ier,
    input  logic [DATA_W-1:0] lcr,
    input  logic [DATA_W-1:0] mcr,
    input  logic [DATA_W-1:0] asr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] line_status,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [DATA_W-1:0] icr_rdata,
    output logic [DATA_W-1:0] rd_val
);
    localparam logic [IDX_W-1:0] CTL_AT = IDX_W'(CTL_IDX);

    logic [DATA_W-1:0] tx_ext, rx_ext, idx_ext, indexed_val;

    // Widen levels and index to the bus width.
    always_comb begin
        tx_ext  = DATA_W'(tx_level);
        rx_ext  = DATA_W'(rx_level);
        idx_ext = DATA_W'(idx);
    end

    // Pick the indexed location: local remap control or the external file.
    always_comb begin
        indexed_val = (idx == CTL_AT) ? ctl : icr_rdata;
    end

    // Address decode for reads under the two remap controls.
    always_comb begin
        case (addr)
            A_IER:   rd_val = ctl[CTL_EXT]    ? asr         : ier;
            A_LCR:   rd_val = ctl[CTL_EXT]    ? tx_ext      : lcr;
            A_MCR:   rd_val = ctl[CTL_EXT]    ? rx_ext      : mcr;
            A_LSR:   rd_val = ctl[CTL_IDX_RD] ? indexed_val : line_status;
            A_IDX:   rd_val = idx_ext;
            default: rd_val = '0;
        endcase
    end
endmodule

// File: rtl/uart_remap_regs.sv
// uart_remap_regs: top of the UART register remapping slice. Joins the
// write-side register storage with the read decode and registers the read
// data on each read strobe. Assumes one bus access per cycle at most,
// with read and write strobes allowed together at the same address.
module uart_remap_regs
    import uart_remap_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int LVL_W   = 8,
    parameter int IDX_W   = 8,
    parameter int CTL_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] line_status,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [DATA_W-1:0] icr_rdata,
    output logic [IDX_W-1:0]  icr_index,
    output logic              icr_wr,
    output logic [DATA_W-1:0] icr_wdata,
    output logic [DATA_W-1:0] ier_q,
    output logic [DATA_W-1:0] lcr_q,
    output logic [DATA_W-1:0] mcr_q,
    output logic [DATA_W-1:0] asr_q,
    output logic [DATA_W-1:0] remap_ctl
);
    logic [DATA_W-1:0] rd_val;

    urr_regs #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .CTL_IDX(CTL_IDX)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ier      (ier_q),
        .lcr      (lcr_q),
        .mcr      (mcr_q),
        .asr      (asr_q),
        .idx      (icr_index),
        .ctl      (remap_ctl),
        .icr_wr   (icr_wr),
        .icr_wdata(icr_wdata)
    );

    urr_rdmux #(
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W),
        .IDX_W  (IDX_W),
        .CTL_IDX(CTL_IDX)
    ) u_rdmux (
        .addr       (bus_addr),
        .ctl        (remap_ctl),
        .ier        (ier_q),
        .lcr        (lcr_q),
        .mcr        (mcr_q),
        .asr        (asr_q),
        .idx        (icr_index),
        .line_status(line_status),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .icr_rdata  (icr_rdata),
        .rd_val     (rd_val)
    );

    // Capture the decoded read value on each read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // R2: read data only moves on a read strobe.
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R7: line status path when indexed reads are off.
    a_r7_lsr_path: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_LSR && !remap_ctl[CTL_IDX_RD])
        |=> (bus_rdata == $past(line_status)));

    // R4: transmit level appears at the line-control address in extended map.
    a_r4_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_LCR && remap_ctl[CTL_EXT])
        |=> (bus_rdata == DATA_W'($past(tx_level))));
endmodule

// File: tb/test_uart_remap_regs.sv
`timescale 1ns/1ps
module test_uart_remap_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] line_status = 8'h61;
    logic [7:0] tx_level = 8'h2A;
    logic [7:0] rx_level = 8'h11;
    logic [7:0] icr_rdata;
    logic [7:0] icr_index;
    logic       icr_wr;
    logic [7:0] icr_wdata;
    logic [7:0] ier_q, lcr_q, mcr_q, asr_q, remap_ctl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    // Model of the external indexed file: content depends on the index.
    assign icr_rdata = icr_index ^ 8'hC3;

    uart_remap_regs i_uart_remap_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .line_status(line_status), .tx_level(tx_level), .rx_level(rx_level),
        .icr_rdata(icr_rdata), .icr_index(icr_index), .icr_wr(icr_wr),
        .icr_wdata(icr_wdata), .ier_q(ier_q), .lcr_q(lcr_q), .mcr_q(mcr_q),
        .asr_q(asr_q), .remap_ctl(remap_ctl)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset();
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 ier", ier_q, 8'h00);
        check("R1 lcr", lcr_q, 8'h00);
        check("R1 mcr", mcr_q, 8'h00);
        check("R1 asr", asr_q, 8'h00);
        check("R1 index", icr_index, 8'h00);
        check("R1 ctl", remap_ctl, 8'h00);
    endtask

    task automatic t_plain();
        bus_write(3'd1, 8'h0F);
        bus_write(3'd3, 8'h83);
        bus_write(3'd4, 8'h1B);
        check("R3 ier store", ier_q, 8'h0F);
        bus_read(3'd1, 8'h0F, "R3 ier read");
        bus_read(3'd3, 8'h83, "R3 lcr read");
        bus_read(3'd4, 8'h1B, "R3 mcr read");
        bus_addr = 3'd1;
        repeat (2) @(negedge clk);
        check("R2 rdata hold", bus_rdata, 8'h1B);
    endtask

    task automatic t_unmapped();
        bus_read(3'd0, 8'h00, "R10 addr0");
        bus_read(3'd2, 8'h00, "R10 addr2");
        bus_read(3'd6, 8'h00, "R10 addr6");
    endtask

    task automatic t_lsr();
        bus_read(3'd5, 8'h61, "R7 line status");
    endtask

    task automatic t_index();
        bus_write(3'd7, 8'h03);
        check("R8 icr_index", icr_index, 8'h03);
        bus_read(3'd7, 8'h03, "R8 index read");
        @(negedge clk);
        bus_addr = 3'd5; bus_wdata = 8'h44; bus_wr = 1'b1;
        #1;
        check("R9 icr_wr", {7'd0, icr_wr}, 8'h01);
        check("R9 icr_wdata", icr_wdata, 8'h44);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check("R9 icr_wr drop", {7'd0, icr_wr}, 8'h00);
        check("R9 ctl unchanged", remap_ctl, 8'h00);
    endtask

    task automatic t_icr_read();
        bus_write(3'd7, 8'h00);
        bus_write(3'd5, 8'h40);
        check("R9 ctl load", remap_ctl, 8'h40);
        bus_read(3'd5, 8'h40, "R7 index0 ctl");
        bus_write(3'd7, 8'h05);
        bus_read(3'd5, 8'h05 ^ 8'hC3, "R7 indexed file");
        bus_write(3'd7, 8'h00);
    endtask

    task automatic t_ext();
        bus_write(3'd5, 8'hC0);
        bus_read(3'd3, 8'h2A, "R4 tx level");
        bus_read(3'd4, 8'h11, "R4 rx level");
        bus_write(3'd3, 8'h07);
        check("R4 lcr write-only", lcr_q, 8'h07);
        bus_read(3'd3, 8'h2A, "R4 tx level after write");
        bus_write(3'd1, 8'h99);
        check("R5 asr store", asr_q, 8'h99);
        check("R5 ier unchanged", ier_q, 8'h0F);
        bus_read(3'd1, 8'h99, "R5 asr read");
    endtask

    task automatic t_norm();
        bus_write(3'd5, 8'h00);
        bus_write(3'd1, 8'h05);
        check("R6 ier store", ier_q, 8'h05);
        check("R6 asr unchanged", asr_q, 8'h99);
        bus_read(3'd1, 8'h05, "R6 ier read");
    endtask

    task automatic t_rdwr();
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = 8'h22; bus_wr = 1'b1; bus_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R11 old value", bus_rdata, 8'h1B);
        check("R11 mcr updated", mcr_q, 8'h22);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_unmapped();
        t_lsr();
        t_index();
        t_icr_read();
        t_ext();
        t_norm();
        t_rdwr();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule